// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block turns one fast master clock into a set of gated CPU-rate and PCI-rate clock waveforms. It can stop and restart each group without ever cutting a pulse short. An internal divider makes the CPU rate, and a ratio select picks divide-by-2 or divide-by-3 of the master clock. A second divider makes the PCI rate at divide-by-6. Because both dividers restart from the same reset, every PCI rising edge coincides with a CPU rising edge.

Three asynchronous active-low controls come in: one stops the CPU clocks, one stops the stoppable PCI clocks, and one powers the whole block down. Each control passes through a two-stage synchronizer. Gating only moves at a period boundary, while the divided clock is low. One PCI output runs free and is never stopped by the PCI stop control. Power down stops every clock output. After power down is released, the clocks restart once a fixed, parameterised wait has passed.

The ratio select and the output-enable input are captured only while reset is held. When the captured output enable is low, every clock output is held low and an enable flag tells the pad ring to float the pins.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, every clock output is 0. `out_en_o` equals the `oe_i` value seen at the last clock edge inside reset.
- R2: With `ratio_fast_i` = 1 captured in reset, the CPU clocks have a 2-cycle period. With 0 captured, the period is 3 cycles. In both cases the clock is high for the first cycle of each period only. Changes of `ratio_fast_i` after reset have no effect.
- R3: The PCI clocks have a 6-cycle period, high for the first 3 cycles. Each PCI rising edge coincides with a CPU rising edge.
- R4: A low on `cpu_stop_ni` is taken through a two-flop synchronizer. The CPU clocks then finish their current period and stay low from the next CPU period boundary onward.
- R5: When `cpu_stop_ni` returns high, the CPU clocks resume at a period boundary, with the same synchronizer delay, starting with a full high phase.
- R6: `pci_stop_ni` (after synchronizing) is captured at each rising edge of the free PCI clock. It controls the stoppable PCI clocks from the PCI period after that capture. While it is low, those clocks stay at 0.
- R7: The free-running PCI output `pci_free_o` keeps toggling whatever `pci_stop_ni` does.
- R8: A synchronized low on `pwr_down_ni` stops the CPU, stoppable PCI and free PCI clocks, each at its next period boundary.
- R9: After `pwr_down_ni` returns high (synchronized), the block waits `PWR_WAIT` master cycles. Each group then restarts at its next period boundary with a full pulse.
- R10: When `out_en_o` is 0, every clock output is 0, whatever the stop and power-down controls do.
- R11: Gating changes only at the last cycle of a period, where the divided clock is low. Every high phase therefore has its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| ratio_fast_i | input | 1 | CPU ratio select, captured in reset (1: /2, 0: /3) |
| oe_i | input | 1 | Output enable, captured in reset |
| cpu_stop_ni | input | 1 | Asynchronous active-low CPU clock stop |
| pci_stop_ni | input | 1 | Asynchronous active-low stop for stoppable PCI clocks |
| pwr_down_ni | input | 1 | Asynchronous active-low power down |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| pci_clk_o | output | N_PCI | Stoppable PCI clocks |
| pci_free_o | output | 1 | Free-running PCI clock (stopped by power down only) |
| out_en_o | output | 1 | Output-buffer enable flag (0: high impedance) |

## Verification
A divider phase that is off by one would shift every CPU or PCI edge. That would show as a miscompare on the first period after reset, within at most six master cycles. A gate register that updates away from a boundary would produce a short or missing pulse within one period of the control change. A wrong synchronizer depth or PCI capture point would move the stop point by a whole period, which shows up within one PCI period. A power-down wait counter with a wrong limit would move the restart by at least a cycle, and that is caught on the first pulse after the wait.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

   typedef enum logic {
      RATIO_SLOW = 1'b0,
      RATIO_FAST = 1'b1
   } cpu_ratio_e;

   // control indices inside the synchronizer bank
   localparam int CTL_CPU   = 0;
   localparam int CTL_PCI   = 1;
   localparam int CTL_PWR   = 2;
   localparam int NUM_CTL   = 3;

   // width of the high phase for a given divide value
   function automatic int high_len(input int div);
      return div / 2;
   endfunction

endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("csc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_q[s] <= RST_VAL;
         end else begin
            if (s == 0) stage_q[s] <= d_i;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/csc_divider.sv
module csc_divider #(
   parameter int CW = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] div_i,
   output logic [CW-1:0] cnt_o,
   output logic          last_o,
   output logic          high_o
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   assign lim = div_i - CW'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (cnt_q >= lim) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CW'(1);
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == lim);
   assign high_o = (cnt_q < (div_i >> 1));

endmodule

// File: rtl/csc_gate.sv
module csc_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic last_i,
   input  logic want_i,
   input  logic raw_i,
   input  logic en_i,
   output logic gate_o,
   output logic clk_o
);

   logic gate_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     gate_q <= 1'b0;
      else if (last_i) gate_q <= want_i;
   end

   assign gate_o = gate_q;
   assign clk_o  = gate_q & raw_i & en_i;

   AST_GATE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_q != $past(gate_q)) |-> ($past(last_i) && !$past(raw_i))); // R11

endmodule

// File: rtl/csc_pwr_seq.sv
module csc_pwr_seq #(
   parameter int PWR_WAIT = 600000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwr_ok_i,
   output logic run_o
);

   localparam int WW = (PWR_WAIT < 2) ? 1 : $clog2(PWR_WAIT);

   if (PWR_WAIT < 1) begin : g_bad_wait
      $error("csc_pwr_seq: PWR_WAIT must be at least 1");
   end

   logic          run_q;
   logic [WW-1:0] wait_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b1;
         wait_q <= '0;
      end else if (!pwr_ok_i) begin
         run_q  <= 1'b0;
         wait_q <= '0;
      end else if (!run_q) begin
         if (wait_q == WW'(PWR_WAIT - 1)) run_q  <= 1'b1;
         else                             wait_q <= wait_q + WW'(1);
      end
   end

   assign run_o = run_q;

   AST_PD_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_ok_i |=> !run_o); // R8

   AST_PD_RESTART_NEEDS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_o) |-> $past(pwr_ok_i)); // R9

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
   import clk_stop_pkg::*;
#(
   parameter int N_CPU       = 2,
   parameter int N_PCI       = 5,
   parameter int CPU_DIV_FAST = 2,
   parameter int CPU_DIV_SLOW = 3,
   parameter int PCI_DIV     = 6,
   parameter int SYNC_STAGES = 2,
   parameter int PWR_WAIT    = 600000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ratio_fast_i,
   input  logic             oe_i,
   input  logic             cpu_stop_ni,
   input  logic             pci_stop_ni,
   input  logic             pwr_down_ni,
   output logic [N_CPU-1:0] cpu_clk_o,
   output logic [N_PCI-1:0] pci_clk_o,
   output logic             pci_free_o,
   output logic             out_en_o
);

   localparam int CW = $clog2(PCI_DIV + 1);

   if (N_CPU < 1 || N_PCI < 1) begin : g_bad_count
      $error("clk_stop_ctrl: need at least one CPU and one PCI output");
   end
   if ((PCI_DIV % CPU_DIV_FAST) != 0 || (PCI_DIV % CPU_DIV_SLOW) != 0) begin : g_bad_ratio
      $error("clk_stop_ctrl: PCI_DIV must be a multiple of both CPU divides");
   end
   if (CPU_DIV_FAST < 2 || CPU_DIV_SLOW < 2) begin : g_bad_div
      $error("clk_stop_ctrl: CPU divides must be at least 2");
   end

   // reset-time straps
   cpu_ratio_e ratio_q;
   logic       oe_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ratio_q <= cpu_ratio_e'(ratio_fast_i);
         oe_q    <= oe_i;
      end
   end

   // control synchronizers
   logic [NUM_CTL-1:0] ctl_raw;
   logic [NUM_CTL-1:0] ctl_sync;

   assign ctl_raw[CTL_CPU] = cpu_stop_ni;
   assign ctl_raw[CTL_PCI] = pci_stop_ni;
   assign ctl_raw[CTL_PWR] = pwr_down_ni;

   for (genvar c = 0; c < NUM_CTL; c++) begin : g_sync
      csc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (ctl_raw[c]),
         .q_o    (ctl_sync[c])
      );
   end

   // dividers
   logic [CW-1:0] cpu_div;
   logic [CW-1:0] cpu_cnt, pci_cnt;
   logic          cpu_last, cpu_high, pci_last, pci_high;

   assign cpu_div = (ratio_q == RATIO_FAST) ? CW'(CPU_DIV_FAST) : CW'(CPU_DIV_SLOW);

   csc_divider #(.CW(CW)) u_cpu_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .div_i  (cpu_div),
      .cnt_o  (cpu_cnt),
      .last_o (cpu_last),
      .high_o (cpu_high)
   );

   csc_divider #(.CW(CW)) u_pci_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .div_i  (CW'(PCI_DIV)),
      .cnt_o  (pci_cnt),
      .last_o (pci_last),
      .high_o (pci_high)
   );

   // power sequencing
   logic run;

   csc_pwr_seq #(.PWR_WAIT(PWR_WAIT)) u_pwr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pwr_ok_i (ctl_sync[CTL_PWR]),
      .run_o    (run)
   );

   // PCI stop capture at the free clock rising edge
   logic pci_stop_lat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pci_stop_lat_q <= 1'b1;
      else if (pci_last) pci_stop_lat_q <= ctl_sync[CTL_PCI];
   end

   // gates
   logic cpu_gate, pci_gate, free_gate;
   logic cpu_clk, pci_clk, free_clk;

   csc_gate u_cpu_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .last_i (cpu_last),
      .want_i (ctl_sync[CTL_CPU] & run),
      .raw_i  (cpu_high),
      .en_i   (oe_q),
      .gate_o (cpu_gate),
      .clk_o  (cpu_clk)
   );

   csc_gate u_pci_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .last_i (pci_last),
      .want_i (pci_stop_lat_q & run),
      .raw_i  (pci_high),
      .en_i   (oe_q),
      .gate_o (pci_gate),
      .clk_o  (pci_clk)
   );

   csc_gate u_free_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .last_i (pci_last),
      .want_i (run),
      .raw_i  (pci_high),
      .en_i   (oe_q),
      .gate_o (free_gate),
      .clk_o  (free_clk)
   );

   for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_out
      assign cpu_clk_o[i] = cpu_clk;
   end
   for (genvar j = 0; j < N_PCI; j++) begin : g_pci_out
      assign pci_clk_o[j] = pci_clk;
   end
   assign pci_free_o = free_clk;
   assign out_en_o   = oe_q;

   // port-level checks
   AST_OE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_en_o |-> (cpu_clk_o == '0 && pci_clk_o == '0 && !pci_free_o)); // R10

   AST_CPU_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cpu_clk_o[0]) |-> (cpu_cnt == '0)); // R5

   AST_CPU_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(cpu_clk_o[0]) && out_en_o) |-> (cpu_cnt == (cpu_div >> 1))); // R11

   AST_FREE_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(pci_free_o) && out_en_o) |-> (pci_cnt == CW'(PCI_DIV / 2))); // R11

   AST_PCI_EDGE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pci_free_o) |-> (cpu_cnt == '0 && cpu_high)); // R3

   AST_PCI_STOPPED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pci_gate) |-> (pci_clk_o == '0)); // R6

   AST_FREE_NEEDS_RUN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pci_last && run) |=> free_gate); // R7

   AST_CPU_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_last && !ctl_sync[CTL_CPU]) |=> (cpu_clk_o == '0)); // R4

endmodule

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb_top;

   localparam int NC   = 2;
   localparam int NP   = 5;
   localparam int WAIT = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ratio_fast = 1'b1;
   logic oe = 1'b1;
   logic cpu_stop_n = 1'b1;
   logic pci_stop_n = 1'b1;
   logic pwr_n = 1'b1;
   logic [NC-1:0] cpu_clk;
   logic [NP-1:0] pci_clk;
   logic pci_free;
   logic out_en;

   always #2.5 clk = ~clk;

   clk_stop_ctrl #(.N_CPU(NC), .N_PCI(NP), .PWR_WAIT(WAIT)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .ratio_fast_i (ratio_fast),
      .oe_i         (oe),
      .cpu_stop_ni  (cpu_stop_n),
      .pci_stop_ni  (pci_stop_n),
      .pwr_down_ni  (pwr_n),
      .cpu_clk_o    (cpu_clk),
      .pci_clk_o    (pci_clk),
      .pci_free_o   (pci_free),
      .out_en_o     (out_en)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   string cur_req = "R1";

   logic [NC+NP+1:0] exp_q[$];
   string            tag_q[$];

   // reference model of the requirements
   int m_ccnt, m_pcnt, m_wait;
   bit m_sel, m_oe, m_cs1, m_cs2, m_ps1, m_ps2, m_ds1, m_ds2;
   bit m_plat, m_gcpu, m_gpci, m_gfree, m_run;

   always @(posedge clk) begin
      int cdiv;
      bit cl, pl, c, p, f;
      if (!rst_n) begin
         m_sel = ratio_fast; m_oe = oe;
         m_ccnt = 0; m_pcnt = 0; m_wait = 0;
         m_cs1 = 1; m_cs2 = 1; m_ps1 = 1; m_ps2 = 1; m_ds1 = 1; m_ds2 = 1;
         m_plat = 1; m_gcpu = 0; m_gpci = 0; m_gfree = 0; m_run = 1;
      end else begin
         cdiv = m_sel ? 2 : 3;
         cl = (m_ccnt == cdiv - 1);
         pl = (m_pcnt == 5);
         if (cl) m_gcpu = m_cs2 & m_run;
         if (pl) begin
            m_gpci  = m_plat & m_run;
            m_plat  = m_ps2;
            m_gfree = m_run;
         end
         if (!m_ds2) begin
            m_run = 0; m_wait = 0;
         end else if (!m_run) begin
            if (m_wait == WAIT - 1) m_run = 1;
            else m_wait++;
         end
         m_cs2 = m_cs1; m_cs1 = cpu_stop_n;
         m_ps2 = m_ps1; m_ps1 = pci_stop_n;
         m_ds2 = m_ds1; m_ds1 = pwr_n;
         m_ccnt = cl ? 0 : m_ccnt + 1;
         m_pcnt = pl ? 0 : m_pcnt + 1;
      end
      cdiv = m_sel ? 2 : 3;
      c = m_gcpu  & (m_ccnt < cdiv / 2) & m_oe;
      p = m_gpci  & (m_pcnt < 3) & m_oe;
      f = m_gfree & (m_pcnt < 3) & m_oe;
      exp_q.push_back({{NC{c}}, {NP{p}}, f, m_oe});
      tag_q.push_back(cur_req);
   end

   // monitor: compare away from the active edge
   always @(negedge clk) begin
      logic [NC+NP+1:0] e, a;
      string t;
      if (exp_q.size() > 0 && !done) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {cpu_clk, pci_clk, pci_free, out_en};
         n_vec++;
         if (a !== e) begin
            n_bad++;
            $display("FAIL %s t=%0t got cpu=%b pci=%b free=%b oe=%b exp cpu=%b pci=%b free=%b oe=%b",
                     t, $time, a[NC+NP+1:NP+2], a[NP+1:2], a[1], a[0],
                     e[NC+NP+1:NP+2], e[NP+1:2], e[1], e[0]);
         end
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input bit sel, input bit en);
      @(negedge clk);
      cur_req = "R1";
      rst_n = 1'b0; ratio_fast = sel; oe = en;
      cpu_stop_n = 1; pci_stop_n = 1; pwr_n = 1;
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      // fast ratio
      do_reset(1'b1, 1'b1);
      cur_req = "R2"; cycles(24);
      cur_req = "R3"; ratio_fast = 1'b0; cycles(24);   // R2: late change ignored
      cur_req = "R4"; cpu_stop_n = 0; cycles(30);
      cur_req = "R5"; cpu_stop_n = 1; cycles(30);
      cur_req = "R6"; pci_stop_n = 0; cycles(36);
      pci_stop_n = 1; cycles(24);
      cur_req = "R7"; pci_stop_n = 0; cycles(30);
      pci_stop_n = 1; cycles(12);
      cur_req = "R11";
      for (int k = 0; k < 40; k++) begin
         cpu_stop_n = (k % 3) != 0;
         pci_stop_n = (k % 5) > 1;
         cycles(1 + (k % 4));
      end
      cpu_stop_n = 1; pci_stop_n = 1; cycles(12);
      cur_req = "R8"; pwr_n = 0; cycles(40);
      cur_req = "R9"; pwr_n = 1; cycles(WAIT + 30);
      // slow ratio
      do_reset(1'b0, 1'b1);
      cur_req = "R2"; ratio_fast = 1'b1; cycles(30);
      cur_req = "R4"; cpu_stop_n = 0; cycles(25);
      cur_req = "R5"; cpu_stop_n = 1; cycles(25);
      cur_req = "R8"; pwr_n = 0; cycles(30);
      cur_req = "R9"; pwr_n = 1; cycles(WAIT + 30);
      // outputs disabled
      do_reset(1'b1, 1'b0);
      cur_req = "R10";
      cycles(20); cpu_stop_n = 0; cycles(10); cpu_stop_n = 1;
      pwr_n = 0; cycles(10); pwr_n = 1; cycles(WAIT + 20);
      cycles(2);
      finish_run();
   end

endmodule